// File: doc/BRIEF.md
# Operand Address Calculator

This unit takes the six-bit operand specifier of an instruction (three bits of mode, three bits of register number) and works out where the operand lives. The caller supplies the contents of the named address register, the program counter value, up to two 16-bit extension words, an index register value and the operand size code. The unit returns a 32-bit effective address when the operand is in memory. It flags the case where the operand is a register or an immediate constant instead. It also reports how many extension words the specifier consumes.

For the post-increment and pre-decrement modes, the unit also produces the new value of the address register. That value is registered: it appears on the write-back outputs one clock after a cycle in which the update enable is high. The step is the operand size in bytes, except that a byte access through register 7 (the stack pointer) steps by two. Two size-code tables are supported, and an input picks which one applies. Unused specifiers and size codes the selected table does not define are reported as illegal.

Top module: `ea_unit`

## Requirements
- R1: Mode 000 (data register) and mode 001 (address register) assert `is_register`, give `ea_addr` = 0 and `ext_words` = 0, and never cause a write-back.
- R2: Mode 010 gives `ea_addr` = `an_value`. Mode 011 gives `ea_addr` = `an_value`. Mode 100 gives `ea_addr` = `an_value` minus the step.
- R3: The step is 1, 2 or 4 for byte, word or long. A byte access with register field 7 steps by 2.
- R4: When `upd_en` is high for a legal mode 011 or 100, then after the next rising edge `an_wr_en` is 1, `an_wr_idx` equals the register field, and `an_wr_data` equals `an_value` plus the step (mode 011) or minus the step (mode 100). In every other case `an_wr_en` is 0 after the edge, and `an_wr_idx` and `an_wr_data` keep their previous values.
- R5: Mode 101 gives `ea_addr` = `an_value` + sign-extended `ext_word0`.
- R6: Mode 110 gives `ea_addr` = `an_value` + sign-extended `ext_word0[7:0]` + index. The index is the full `index_value` when `index_long` = 1, and sign-extended `index_value[15:0]` otherwise.
- R7: Mode 111 with register 000 gives `ea_addr` = sign-extended `ext_word0`. With register 001 it gives `ea_addr` = {`ext_word0`, `ext_word1`}.
- R8: Mode 111 with register 010 gives `pc_value` + sign-extended `ext_word0`. With register 011 it gives `pc_value` + sign-extended `ext_word0[7:0]` + index, where the index follows R6.
- R9: Mode 111 with register 100 asserts `is_immediate` and gives `ea_addr` = 0. `imm_data` is `ext_word0[7:0]` zero-extended for byte, `ext_word0` zero-extended for word, and {`ext_word0`, `ext_word1`} for long.
- R10: With `move_sizes` = 0, size codes 00/01/10 mean byte/word/long. With `move_sizes` = 1, codes 01/11/10 mean byte/word/long. The remaining code of each table asserts `illegal`.
- R11: Mode 111 with register 101, 110 or 111 asserts `illegal`. Whenever `illegal` is high, `is_register`, `is_immediate`, `ext_words` and `ea_addr` are all 0, and no write-back follows.
- R12: `ext_words` is 0 for modes 000–100. It is 1 for modes 101 and 110 and for mode 111 with register 000, 010 or 011. It is 2 for mode 111 with register 001. For the immediate it is 2 when the size is long and 1 otherwise.
- R13: While `rst_n` is low, `an_wr_en` and `an_wr_idx` are 0 and `an_wr_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_field | input | 6 | Mode in [5:3], register number in [2:0] |
| size_code | input | 2 | Operand size code |
| move_sizes | input | 1 | Selects the alternate size-code table |
| an_value | input | 32 | Contents of the address register named by the field |
| pc_value | input | 32 | Program counter base for relative modes |
| ext_word0 | input | 16 | First extension word |
| ext_word1 | input | 16 | Second extension word |
| index_value | input | 32 | Index register contents |
| index_long | input | 1 | Use the full index instead of the sign-extended low half |
| upd_en | input | 1 | Commit the address-register side effect on this edge |
| ea_addr | output | 32 | Effective address |
| imm_data | output | 32 | Immediate operand value |
| is_register | output | 1 | Operand is a register |
| is_immediate | output | 1 | Operand is an immediate |
| illegal | output | 1 | Unsupported specifier or size code |
| ext_words | output | 2 | Extension words consumed |
| an_wr_en | output | 1 | Registered write-back strobe |
| an_wr_idx | output | 3 | Registered write-back register number |
| an_wr_data | output | 32 | Registered write-back value |

## Verification
A wrong decode of the mode or sub-mode shows up in the same cycle as a wrong address, a wrong flag or a wrong extension-word count. A reference model sees such a difference on the very clock that presents the field. A faulty step or a faulty side-effect gate stays invisible on the address for post-increment. It surfaces one edge later on the write-back strobe or data. A stale or leaking write-back register shows up on the first idle cycle after an update. For that reason, updates are interleaved with cycles where `upd_en` is low and with illegal specifiers.

// File: rtl/ea_pkg.sv
// Package: shared kinds and size encoding for the operand address calculator.
// Assumes a 32-bit address space and 16-bit extension words.
package ea_pkg;
    localparam int AW  = 32;
    localparam int EXW = 16;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} opsize_t;

    typedef enum logic [3:0] {
        K_DREG, K_AREG, K_IND, K_POST, K_PRE, K_DISP, K_INDEX,
        K_ABSW, K_ABSL, K_PCD, K_PCX, K_IMM, K_BAD
    } ea_kind_t;

    typedef struct packed {
        ea_kind_t   kind;
        opsize_t    size;
        logic       bad;
        logic [1:0] ext;
        logic [2:0] regno;
    } ea_dec_t;
endpackage

// File: rtl/ea_mode_decode.sv
// Module: classifies the specifier and size code.
// It yields the addressing kind, the operand size, the extension-word count and an illegal flag.
// Assumes: purely combinational; the illegal flag forces the extension count to zero.
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [5:0] field,
    input  logic [1:0] size_code,
    input  logic       move_sizes,
    output ea_dec_t    dec
);
    logic [2:0] mode;
    logic [2:0] rg;
    ea_kind_t   kind;
    opsize_t    size;
    logic       size_bad;
    logic [1:0] ext_raw;

    assign mode = field[5:3];
    assign rg   = field[2:0];

    // Map the mode and sub-mode bits to an addressing kind.
    always_comb begin
        unique case (mode)
            3'b000: kind = K_DREG;
            3'b001: kind = K_AREG;
            3'b010: kind = K_IND;
            3'b011: kind = K_POST;
            3'b100: kind = K_PRE;
            3'b101: kind = K_DISP;
            3'b110: kind = K_INDEX;
            default: begin
                unique case (rg)
                    3'b000:  kind = K_ABSW;
                    3'b001:  kind = K_ABSL;
                    3'b010:  kind = K_PCD;
                    3'b011:  kind = K_PCX;
                    3'b100:  kind = K_IMM;
                    default: kind = K_BAD;
                endcase
            end
        endcase
    end

    // Translate the size code through whichever table is selected.
    always_comb begin
        size_bad = 1'b0;
        size     = SZ_WORD;
        if (move_sizes) begin
            unique case (size_code)
                2'b01:   size = SZ_BYTE;
                2'b11:   size = SZ_WORD;
                2'b10:   size = SZ_LONG;
                default: size_bad = 1'b1;
            endcase
        end else begin
            unique case (size_code)
                2'b00:   size = SZ_BYTE;
                2'b01:   size = SZ_WORD;
                2'b10:   size = SZ_LONG;
                default: size_bad = 1'b1;
            endcase
        end
    end

    // Count the extension words each kind consumes.
    always_comb begin
        unique case (kind)
            K_DISP, K_INDEX, K_ABSW, K_PCD, K_PCX: ext_raw = 2'd1;
            K_ABSL:                                 ext_raw = 2'd2;
            K_IMM:   ext_raw = (size == SZ_LONG) ? 2'd2 : 2'd1;
            default:                                ext_raw = 2'd0;
        endcase
    end

    // Assemble the decode record.
    always_comb begin
        dec.kind  = kind;
        dec.size  = size;
        dec.bad   = (kind == K_BAD) || size_bad;
        dec.ext   = dec.bad ? 2'd0 : ext_raw;
        dec.regno = rg;
    end
endmodule

// File: rtl/ea_addr_calc.sv
// Module: forms the effective address, the immediate value and the updated register value.
// Assumes: the decode record is valid in the same cycle; illegal kinds yield zeros.
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int EXT_W  = EXW
) (
    input  ea_dec_t             dec,
    input  logic [ADDR_W-1:0]   an_value,
    input  logic [ADDR_W-1:0]   pc_value,
    input  logic [EXT_W-1:0]    ext0,
    input  logic [EXT_W-1:0]    ext1,
    input  logic [ADDR_W-1:0]   index_value,
    input  logic                index_long,
    output logic [ADDR_W-1:0]   ea,
    output logic [ADDR_W-1:0]   imm,
    output logic [ADDR_W-1:0]   an_next,
    output logic                side_fx
);
    localparam int HALF = EXT_W;
    localparam int BYTE = 8;

    logic [ADDR_W-1:0] d16;
    logic [ADDR_W-1:0] d8;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] an_inc;
    logic [ADDR_W-1:0] an_dec;

    // Sign-extend the displacements and the selected index form.
    always_comb begin
        d16 = {{(ADDR_W-HALF){ext0[HALF-1]}}, ext0};
        d8  = {{(ADDR_W-BYTE){ext0[BYTE-1]}}, ext0[BYTE-1:0]};
        idx = index_long ? index_value
                         : {{(ADDR_W-HALF){index_value[HALF-1]}}, index_value[HALF-1:0]};
    end

    // Choose the register step from size, keeping the stack pointer even.
    always_comb begin
        unique case (dec.size)
            SZ_BYTE: step = (dec.regno == 3'd7) ? ADDR_W'(2) : ADDR_W'(1);
            SZ_WORD: step = ADDR_W'(2);
            default: step = ADDR_W'(4);
        endcase
        an_inc = an_value + step;
        an_dec = an_value - step;
    end

    // Select the effective address for the current kind.
    always_comb begin
        ea = '0;
        if (!dec.bad) begin
            unique case (dec.kind)
                K_IND, K_POST: ea = an_value;
                K_PRE:         ea = an_dec;
                K_DISP:        ea = an_value + d16;
                K_INDEX:       ea = an_value + d8 + idx;
                K_ABSW:        ea = d16;
                K_ABSL:        ea = ADDR_W'({ext0, ext1});
                K_PCD:         ea = pc_value + d16;
                K_PCX:         ea = pc_value + d8 + idx;
                default:       ea = '0;
            endcase
        end
    end

    // Build the immediate operand at the requested size.
    always_comb begin
        unique case (dec.size)
            SZ_BYTE: imm = ADDR_W'(ext0[BYTE-1:0]);
            SZ_WORD: imm = ADDR_W'(ext0);
            default: imm = ADDR_W'({ext0, ext1});
        endcase
        if (dec.bad || dec.kind != K_IMM) imm = '0;
    end

    // Produce the side-effect value and whether one applies.
    always_comb begin
        side_fx = !dec.bad && (dec.kind == K_POST || dec.kind == K_PRE);
        an_next = (dec.kind == K_PRE) ? an_dec : an_inc;
    end
endmodule

// File: rtl/ea_wb_reg.sv
// Module: holds the address-register write-back for one clock.
// The strobe is high only after an edge where the update was enabled and applicable.
// Assumes: synchronous active-low reset; data and index hold when no update is taken.
module ea_wb_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [2:0]        idx_in,
    input  logic [ADDR_W-1:0] data_in,
    output logic              wr_en,
    output logic [2:0]        wr_idx,
    output logic [ADDR_W-1:0] wr_data
);
    // Capture the side effect on the enabled edge and clear the strobe otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= take;
            if (take) begin
                wr_idx  <= idx_in;
                wr_data <= data_in;
            end
        end
    end
endmodule

// File: rtl/ea_unit.sv
// Module: top of the operand address calculator.
// It ties the decode, the address arithmetic and the registered write-back together.
// Assumes: the caller presents the named address register's contents and the extension words.
module ea_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  ea_field,
    input  logic [1:0]  size_code,
    input  logic        move_sizes,
    input  logic [31:0] an_value,
    input  logic [31:0] pc_value,
    input  logic [15:0] ext_word0,
    input  logic [15:0] ext_word1,
    input  logic [31:0] index_value,
    input  logic        index_long,
    input  logic        upd_en,
    output logic [31:0] ea_addr,
    output logic [31:0] imm_data,
    output logic        is_register,
    output logic        is_immediate,
    output logic        illegal,
    output logic [1:0]  ext_words,
    output logic        an_wr_en,
    output logic [2:0]  an_wr_idx,
    output logic [31:0] an_wr_data
);
    import ea_pkg::*;

    ea_dec_t     dec;
    logic [31:0] an_next;
    logic        side_fx;

    ea_mode_decode u_dec (
        .field(ea_field), .size_code(size_code), .move_sizes(move_sizes), .dec(dec)
    );

    ea_addr_calc #(.ADDR_W(AW), .EXT_W(EXW)) u_calc (
        .dec(dec), .an_value(an_value), .pc_value(pc_value),
        .ext0(ext_word0), .ext1(ext_word1),
        .index_value(index_value), .index_long(index_long),
        .ea(ea_addr), .imm(imm_data), .an_next(an_next), .side_fx(side_fx)
    );

    ea_wb_reg #(.ADDR_W(AW)) u_wb (
        .clk(clk), .rst_n(rst_n), .take(upd_en && side_fx),
        .idx_in(dec.regno), .data_in(an_next),
        .wr_en(an_wr_en), .wr_idx(an_wr_idx), .wr_data(an_wr_data)
    );

    // Drive the operand-class flags from the decode record.
    always_comb begin
        illegal      = dec.bad;
        ext_words    = dec.ext;
        is_register  = !dec.bad && (dec.kind == K_DREG || dec.kind == K_AREG);
        is_immediate = !dec.bad && (dec.kind == K_IMM);
    end
endmodule

// File: rtl/ea_unit_chk.sv
// Module: temporal checks on the operand address calculator, bound to the top.
// Assumes: synchronous active-low reset; all checks are disabled while reset is low.
module ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  ea_field,
    input logic        upd_en,
    input logic [31:0] an_value,
    input logic [31:0] ea_addr,
    input logic        is_register,
    input logic        is_immediate,
    input logic        illegal,
    input logic [1:0]  ext_words,
    input logic        an_wr_en,
    input logic [2:0]  an_wr_idx,
    input logic [31:0] an_wr_data
);
    logic auto_mode;
    assign auto_mode = (ea_field[5:3] == 3'b011) || (ea_field[5:3] == 3'b100);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_register, is_immediate, illegal})); // R11

    AST_EXT_NEVER_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_words != 2'd3); // R12

    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !an_wr_en); // R11

    AST_NO_WB_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> !an_wr_en); // R4

    AST_WB_ONLY_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !auto_mode) |=> !an_wr_en); // R4

    AST_PREDEC_WB_MATCHES_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !illegal && ea_field[5:3] == 3'b100) |=> (an_wr_en && an_wr_data == $past(ea_addr))); // R2

    AST_POSTINC_EA_IS_AN: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal && ea_field[5:3] == 3'b011) |-> ea_addr == an_value); // R2

    AST_SP_STAYS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !illegal && auto_mode && ea_field[2:0] == 3'd7) |=>
        (an_wr_idx == 3'd7 && an_wr_data[0] == $past(an_value[0]))); // R3
endmodule

bind ea_unit ea_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ea_field(ea_field), .upd_en(upd_en),
    .an_value(an_value), .ea_addr(ea_addr), .is_register(is_register),
    .is_immediate(is_immediate), .illegal(illegal), .ext_words(ext_words),
    .an_wr_en(an_wr_en), .an_wr_idx(an_wr_idx), .an_wr_data(an_wr_data)
);

// File: tb/ea_unit_test.sv
module ea_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  ea_field;
    logic [1:0]  size_code;
    logic        move_sizes;
    logic [31:0] an_value, pc_value, index_value;
    logic [15:0] ext_word0, ext_word1;
    logic        index_long, upd_en;
    logic [31:0] ea_addr, imm_data, an_wr_data;
    logic        is_register, is_immediate, illegal, an_wr_en;
    logic [1:0]  ext_words;
    logic [2:0]  an_wr_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Expected registered state, advanced once per clock.
    logic        x_wen = 0;
    logic [2:0]  x_widx = 0;
    logic [31:0] x_wdata = 0;

    always #2.5 clk = ~clk;

    ea_unit uut (.*);

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (field %o size %b sel %b)",
                     req, what, act, exp, ea_field, size_code, move_sizes);
        end
    endtask

    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction
    function automatic logic [31:0] sx8(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    // Behavioural reference: compare every output for the current inputs.
    task automatic compare_now();
        int bytes, step, m, r;
        logic [31:0] e_ea, e_imm, ix, e_wb;
        logic e_reg, e_imm_f, e_ill, fx;
        int e_ext;
        string tag;
        m = ea_field[5:3]; r = ea_field[2:0];
        if (move_sizes) bytes = (size_code == 1) ? 1 : (size_code == 3) ? 2 : (size_code == 2) ? 4 : 0;
        else            bytes = (size_code == 0) ? 1 : (size_code == 1) ? 2 : (size_code == 2) ? 4 : 0;
        step = (bytes == 1 && r == 7) ? 2 : bytes;
        ix = index_long ? index_value : sx16(index_value[15:0]);
        e_ea = 0; e_imm = 0; e_reg = 0; e_imm_f = 0; e_ext = 0; fx = 0;
        e_ill = (bytes == 0) || (m == 7 && r > 4);
        e_wb = 0;
        case (m)
            0, 1: begin e_reg = 1; tag = "R1"; end
            2: begin e_ea = an_value; tag = "R2"; end
            3: begin e_ea = an_value; fx = 1; e_wb = an_value + step; tag = "R3"; end
            4: begin e_ea = an_value - step; fx = 1; e_wb = an_value - step; tag = "R3"; end
            5: begin e_ea = an_value + sx16(ext_word0); e_ext = 1; tag = "R5"; end
            6: begin e_ea = an_value + sx8(ext_word0[7:0]) + ix; e_ext = 1; tag = "R6"; end
            default: case (r)
                0: begin e_ea = sx16(ext_word0); e_ext = 1; tag = "R7"; end
                1: begin e_ea = {ext_word0, ext_word1}; e_ext = 2; tag = "R7"; end
                2: begin e_ea = pc_value + sx16(ext_word0); e_ext = 1; tag = "R8"; end
                3: begin e_ea = pc_value + sx8(ext_word0[7:0]) + ix; e_ext = 1; tag = "R8"; end
                4: begin
                    e_imm_f = 1; e_ext = (bytes == 4) ? 2 : 1; tag = "R9";
                    e_imm = (bytes == 1) ? {24'd0, ext_word0[7:0]} :
                            (bytes == 2) ? {16'd0, ext_word0} : {ext_word0, ext_word1};
                end
                default: tag = "R11";
            endcase
        endcase
        if (bytes == 0) tag = "R10";
        if (e_ill) begin e_ea = 0; e_imm = 0; e_reg = 0; e_imm_f = 0; e_ext = 0; fx = 0; end
        check(tag, "ea_addr", ea_addr, e_ea);
        check(tag, "imm_data", imm_data, e_imm);
        check(tag, "is_register", 32'(is_register), 32'(e_reg));
        check(tag, "is_immediate", 32'(is_immediate), 32'(e_imm_f));
        check(tag, "illegal", 32'(illegal), 32'(e_ill));
        check("R12", "ext_words", 32'(ext_words), 32'(e_ext));
        check("R4", "an_wr_en", 32'(an_wr_en), 32'(x_wen));
        check("R4", "an_wr_idx", 32'(an_wr_idx), 32'(x_widx));
        check("R4", "an_wr_data", an_wr_data, x_wdata);
        // Advance the expected registered state for the coming edge.
        x_wen = upd_en && fx;
        if (x_wen) begin x_widx = 3'(r); x_wdata = e_wb; end
    endtask

    task automatic apply(input logic [5:0] f, input logic [1:0] sz, input logic ms,
                         input logic [31:0] an, input logic [15:0] e0, input logic [15:0] e1,
                         input logic [31:0] ix, input logic il, input logic up);
        @(posedge clk); #1;
        ea_field = f; size_code = sz; move_sizes = ms; an_value = an;
        ext_word0 = e0; ext_word1 = e1; index_value = ix; index_long = il; upd_en = up;
        pc_value = 32'h0004_0100;
        @(negedge clk);
        compare_now();
    endtask

    initial begin
        rst_n = 0; ea_field = 0; size_code = 0; move_sizes = 0; an_value = 0; pc_value = 0;
        ext_word0 = 0; ext_word1 = 0; index_value = 0; index_long = 0; upd_en = 1;
        repeat (3) @(negedge clk);
        // R13: reset clears the write-back outputs.
        check("R13", "an_wr_en", 32'(an_wr_en), 0);
        check("R13", "an_wr_idx", 32'(an_wr_idx), 0);
        check("R13", "an_wr_data", an_wr_data, 0);
        @(posedge clk); #1 rst_n = 1; upd_en = 0;

        // Directed cases with hand values.
        apply(6'o47, 2'b00, 0, 32'h1000, 0, 0, 0, 0, 1);   // byte predec on A7
        check("R3", "A7 byte predec ea", ea_addr, 32'h0FFE);
        apply(6'o33, 2'b00, 0, 32'h2000, 0, 0, 0, 0, 1);   // byte postinc on A3
        check("R4", "A7 wb data", an_wr_data, 32'h0FFE);
        apply(6'o23, 2'b10, 1, 32'h3000, 0, 0, 0, 0, 0);   // idle cycle, move table long
        check("R4", "A3 byte wb data", an_wr_data, 32'h2001);
        apply(6'o65, 2'b01, 0, 32'h100, 16'hFF80, 0, 32'h0000_FFFE, 0, 0);
        check("R6", "index short", ea_addr, 32'h0000_007E);
        apply(6'o65, 2'b01, 0, 32'h100, 16'h0010, 0, 32'h0001_0000, 1, 0);
        check("R6", "index long", ea_addr, 32'h0001_0110);
        apply(6'o71, 2'b01, 0, 0, 16'hDEAD, 16'hBEEF, 0, 0, 0);
        check("R7", "abs long", ea_addr, 32'hDEAD_BEEF);
        apply(6'o74, 2'b11, 1, 0, 16'h8001, 0, 0, 0, 0);
        check("R9", "imm word", imm_data, 32'h0000_8001);
        apply(6'o76, 2'b01, 0, 32'h500, 0, 0, 0, 0, 1);
        apply(6'o34, 2'b11, 0, 32'h500, 0, 0, 0, 0, 1);     // bad size in normal table
        apply(6'o34, 2'b00, 1, 32'h500, 0, 0, 0, 0, 1);     // bad size in move table
        check("R10", "move table 00 illegal", 32'(illegal), 1);
        apply(6'o12, 2'b01, 0, 32'h500, 0, 0, 0, 0, 1);     // register direct with enable
        apply(6'o40, 2'b01, 0, 32'h500, 0, 0, 0, 0, 1);

        // Mixed random traffic.
        for (int i = 0; i < 3000; i++)
            apply(6'($urandom), 2'($urandom), 1'($urandom), $urandom, 16'($urandom),
                  16'($urandom), $urandom, 1'($urandom), 1'($urandom));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule